// File: doc/BRIEF.md
# Load/Store Address Generator

This block turns the operand fields of one load or store into the byte address the memory pipeline will use. It also produces the updated base value for addressing forms that write the base register back. A request carries a 64-bit base register value, the program counter, a register offset, a raw immediate field, an access size code, an addressing-mode code and an access-class code. The class separates ordinary scalar accesses, vector accesses, register pairs, non-temporal pairs, and the exclusive and ordered accesses.

Each access class accepts only some addressing modes. The immediate width, its signedness and its scaling depend on the mode and on the class. A combination that the class does not accept raises an illegal flag, and the block then reports no write-back. A separate flag reports an address that is not a whole multiple of the access size. This flag is for information only.

Results leave through one register stage. A valid/ready handshake sits on both sides, so an accepted request appears on the outputs one cycle later and stays there until the consumer takes it.

Top module: `lsu_addr_gen`

## Requirements
- R1: A request accepted while `in_valid` and `in_ready` are both high appears with `out_valid` high on the next cycle. `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, every output holds its value.
- R2: While `rst_n` is low, `out_valid` is 0 and `in_ready` is 1.
- R3: Mode 1 with class 0 (scalar) or 1 (vector) gives the address `base + (zero-extended imm[11:0] << size)`, with no write-back. Mode 0 gives the address `base`, with no write-back, for classes 0 to 4. Size code s selects an access of 2^s bytes.
- R4: Mode 4 adds `reg_off`. Mode 5 adds `reg_off[31:0]` sign-extended to 64 bits. In both, when `imm[0]` is 1 the offset is first shifted left by the size code. Both are legal only for classes 0 and 1 and never write back.
- R5: For classes 0 and 1, modes 2 (pre) and 3 (post) use the offset `imm[8:0]` sign-extended and not scaled. Write-back is enabled and its value is `base + offset`. The address is `base + offset` for pre and `base` for post.
- R6: Mode 6 (post by register) is legal only for class 1. It gives the address `base`, the write-back value `base + reg_off`, and write-back enabled. Any other class is illegal.
- R7: Mode 7 (literal) gives the address `pc + (sign-extended imm[18:0] << 2)`, with no write-back. It is legal only for classes 0 and 1 with a size code of 2 or more.
- R8: For class 2 (pair), modes 1, 2 and 3 use the offset `imm[6:0]` sign-extended and shifted left by the size code, with the same pre and post rules as R5. Modes 4 to 7 are illegal for this class.
- R9: Class 3 (non-temporal pair) accepts only modes 0 and 1, the latter with the R8 offset. It never writes back.
- R10: Class 4 (exclusive or ordered) accepts only mode 0. Classes 5 to 7 are illegal in every mode.
- R11: For a legal request, `out_misalign` is 1 exactly when the low s bits of the address are not all zero.
- R12: For an illegal request, `out_illegal` is 1 and `out_addr`, `out_wb_data`, `out_wb_en` and `out_misalign` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken |
| cls | input | 3 | Access class code |
| mode | input | 3 | Addressing-mode code |
| size | input | 2 | Access size, 2^size bytes |
| base | input | 64 | Base register value |
| pc | input | 64 | Program counter |
| reg_off | input | 64 | Register offset |
| imm | input | 19 | Raw immediate field |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_addr | output | 64 | Effective address |
| out_wb_data | output | 64 | Base write-back value |
| out_wb_en | output | 1 | Base write-back enable |
| out_illegal | output | 1 | Class and mode combination not allowed |
| out_misalign | output | 1 | Address not a multiple of the access size |

## Verification
The hardest case to reach is the one where the legality decision and the offset selection disagree. Examples are a pair class reaching the literal path, or a vector-only register post-increment reached from a scalar class. A directed test would miss such corners. The bench therefore sweeps every class, mode and size code against immediates whose sign bits sit at each width boundary (7, 9, 12 and 19 bits). It then holds a result under back-pressure while new inputs are presented, which shows that a stalled output cannot be overwritten.

// File: rtl/lsu_addr_gen.sv
module lsu_addr_gen #(
  parameter int AW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [2:0]    cls,
  input  logic [2:0]    mode,
  input  logic [1:0]    size,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] pc,
  input  logic [AW-1:0] reg_off,
  input  logic [18:0]   imm,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [AW-1:0] out_addr,
  output logic [AW-1:0] out_wb_data,
  output logic          out_wb_en,
  output logic          out_illegal,
  output logic          out_misalign
);
  localparam logic [2:0] C_SCALAR = 3'd0, C_VEC = 3'd1, C_PAIR = 3'd2,
                         C_PAIR_NT = 3'd3, C_EXCL = 3'd4;

  logic          is_pair, is_plain, use_pc, post, wb, legal, take;
  logic [AW-1:0] u12_s, s9, s7_s, lit_s, r64_s, r32_s, off, sum, ea;
  logic [3:0]    size_mask;

  assign is_pair  = (cls == C_PAIR) || (cls == C_PAIR_NT);
  assign is_plain = (cls == C_SCALAR) || (cls == C_VEC);

  assign u12_s = AW'(imm[11:0]) << size;
  assign s9    = {{(AW-9){imm[8]}}, imm[8:0]};
  assign s7_s  = {{(AW-7){imm[6]}}, imm[6:0]} << size;
  assign lit_s = {{(AW-19){imm[18]}}, imm} << 2;
  assign r64_s = imm[0] ? (reg_off << size) : reg_off;
  assign r32_s = imm[0] ? ({{(AW-32){reg_off[31]}}, reg_off[31:0]} << size)
                        : {{(AW-32){reg_off[31]}}, reg_off[31:0]};

  always_comb begin
    off    = '0;
    use_pc = 1'b0;
    post   = 1'b0;
    wb     = 1'b0;
    legal  = 1'b0;
    case (mode)
      3'd0: legal = (cls <= C_EXCL);
      3'd1: begin
        off   = is_pair ? s7_s : u12_s;
        legal = is_plain || is_pair;
      end
      3'd2, 3'd3: begin
        off   = is_pair ? s7_s : s9;
        post  = (mode == 3'd3);
        wb    = 1'b1;
        legal = is_plain || (cls == C_PAIR);
      end
      3'd4: begin
        off   = r64_s;
        legal = is_plain;
      end
      3'd5: begin
        off   = r32_s;
        legal = is_plain;
      end
      3'd6: begin
        off   = reg_off;
        post  = 1'b1;
        wb    = 1'b1;
        legal = (cls == C_VEC);
      end
      default: begin
        off    = lit_s;
        use_pc = 1'b1;
        legal  = is_plain && (size >= 2'd2);
      end
    endcase
  end

  assign sum       = (use_pc ? pc : base) + off;
  assign ea        = post ? base : sum;
  assign size_mask = 4'((5'd1 << size) - 5'd1);

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      out_addr     <= '0;
      out_wb_data  <= '0;
      out_wb_en    <= 1'b0;
      out_illegal  <= 1'b0;
      out_misalign <= 1'b0;
    end else begin
      if (in_ready) out_valid <= in_valid;
      if (take) begin
        out_addr     <= legal ? ea : '0;
        out_wb_data  <= (legal && wb) ? sum : '0;
        out_wb_en    <= legal && wb;
        out_illegal  <= !legal;
        out_misalign <= legal && ((ea[3:0] & size_mask) != 4'd0);
      end
    end
  end
endmodule

// File: rtl/lsu_addr_gen_chk.sv
module lsu_addr_gen_chk #(
  parameter int AW = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic [2:0]    cls,
  input logic [2:0]    mode,
  input logic [1:0]    size,
  input logic          out_valid,
  input logic          out_ready,
  input logic [AW-1:0] out_addr,
  input logic [AW-1:0] out_wb_data,
  input logic          out_wb_en,
  input logic          out_illegal,
  input logic          out_misalign
);
  logic acc;
  assign acc = in_valid && in_ready;

  AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> !out_valid); // R2
  AST_ACCEPT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_valid); // R1
  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_addr) && $stable(out_wb_data)
    && $stable(out_illegal) && $stable(out_wb_en)); // R1
  AST_POSTREG_VEC_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    acc && mode == 3'd6 && cls != 3'd1 |=> out_illegal); // R6
  AST_LIT_WIDE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    acc && mode == 3'd7 && size < 2'd2 |=> out_illegal); // R7
  AST_NT_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
    acc && cls == 3'd3 |=> !out_wb_en); // R9
  AST_EXCL_BARE: assert property (@(posedge clk) disable iff (!rst_n)
    acc && cls == 3'd4 && mode != 3'd0 |=> out_illegal); // R10
  AST_MISALIGN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_misalign |-> out_addr[2:0] != 3'd0); // R11
  AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_illegal |-> !out_wb_en && !out_misalign && out_addr == '0); // R12
endmodule

bind lsu_addr_gen lsu_addr_gen_chk #(.AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .cls(cls), .mode(mode), .size(size), .out_valid(out_valid),
  .out_ready(out_ready), .out_addr(out_addr), .out_wb_data(out_wb_data),
  .out_wb_en(out_wb_en), .out_illegal(out_illegal), .out_misalign(out_misalign)
);

// File: tb/lsu_addr_gen_tb_top.sv
module lsu_addr_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, out_ready = 1'b1;
  logic        in_ready, out_valid, out_wb_en, out_illegal, out_misalign;
  logic [2:0]  cls = '0, mode = '0;
  logic [1:0]  size = '0;
  logic [63:0] base = '0, pc = '0, reg_off = '0, out_addr, out_wb_data;
  logic [18:0] imm = '0;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  lsu_addr_gen dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .cls(cls), .mode(mode), .size(size), .base(base), .pc(pc),
    .reg_off(reg_off), .imm(imm), .out_valid(out_valid), .out_ready(out_ready),
    .out_addr(out_addr), .out_wb_data(out_wb_data), .out_wb_en(out_wb_en),
    .out_illegal(out_illegal), .out_misalign(out_misalign)
  );

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic string tag(input [2:0] c, input [2:0] m);
    if (c > 3'd4) return "R10";
    if (c == 3'd4) return "R10";
    if (c == 3'd3) return "R9";
    if (c == 3'd2 && m != 3'd0) return "R8";
    case (m)
      3'd0, 3'd1: return "R3";
      3'd2, 3'd3: return "R5";
      3'd4, 3'd5: return "R4";
      3'd6: return "R6";
      default: return "R7";
    endcase
  endfunction

  function automatic void model(input [2:0] c, input [2:0] m, input [1:0] s,
      input [63:0] b, input [63:0] p, input [63:0] r, input [18:0] im,
      output logic [63:0] ea, output logic [63:0] wd, output logic we,
      output logic il, output logic mis);
    logic [63:0] o;
    logic ok, pre_f, post_f;
    longint unsigned sc;
    sc = 64'd1 << s;
    o = 0; ok = 0; pre_f = 0; post_f = 0;
    ea = b;
    if (m == 3'd0) ok = (c <= 3'd4);
    else if (m == 3'd1 && (c == 3'd2 || c == 3'd3)) begin ok = 1; o = 64'($signed(im[6:0])) * sc; end
    else if (m == 3'd1 && c <= 3'd1) begin ok = 1; o = 64'(im[11:0]) * sc; end
    else if ((m == 3'd2 || m == 3'd3) && c == 3'd2) begin
      ok = 1; o = 64'($signed(im[6:0])) * sc; pre_f = (m == 3'd2); post_f = (m == 3'd3);
    end else if ((m == 3'd2 || m == 3'd3) && c <= 3'd1) begin
      ok = 1; o = 64'($signed(im[8:0])); pre_f = (m == 3'd2); post_f = (m == 3'd3);
    end else if (m == 3'd4 && c <= 3'd1) begin ok = 1; o = im[0] ? r * sc : r; end
    else if (m == 3'd5 && c <= 3'd1) begin
      ok = 1; o = 64'($signed(r[31:0])); if (im[0]) o = o * sc;
    end else if (m == 3'd6 && c == 3'd1) begin ok = 1; o = r; post_f = 1; end
    else if (m == 3'd7 && c <= 3'd1 && s >= 2) begin ok = 1; o = 64'($signed(im)) * 4; end
    if (m == 3'd7) ea = p + o;
    else if (post_f) ea = b;
    else ea = b + o;
    we = ok && (pre_f || post_f);
    wd = we ? b + o : 0;
    il = !ok;
    if (!ok) ea = 0;
    mis = ok && ((ea % sc) != 0);
  endfunction

  task automatic run_one(input [2:0] c, input [2:0] m, input [1:0] s,
      input [63:0] b, input [63:0] p, input [63:0] r, input [18:0] im);
    logic [63:0] ea, wd;
    logic we, il, mis;
    string t;
    model(c, m, s, b, p, r, im, ea, wd, we, il, mis);
    t = tag(c, m);
    @(negedge clk);
    cls = c; mode = m; size = s; base = b; pc = p; reg_off = r; imm = im; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R1", "out_valid", 64'(out_valid), 64'd1);
    chk(il ? "R12" : t, "addr", out_addr, ea);
    chk(il ? "R12" : t, "wb_data", out_wb_data, wd);
    chk(il ? "R12" : t, "wb_en", 64'(out_wb_en), 64'(we));
    chk(il ? "R12" : t, "illegal", 64'(out_illegal), 64'(il));
    chk(il ? "R12" : "R11", "misalign", 64'(out_misalign), 64'(mis));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [18:0] imms [4];
    logic [63:0] bases [2];
    imms[0] = 19'h00005; imms[1] = 19'h7FFFF; imms[2] = 19'h40C41; imms[3] = 19'h3F1BF;
    bases[0] = 64'h0000_0000_0001_0000; bases[1] = 64'h8000_0000_0000_0103;
    repeat (3) @(negedge clk);
    chk("R2", "out_valid in reset", 64'(out_valid), 64'd0);
    chk("R2", "in_ready in reset", 64'(in_ready), 64'd1);
    @(negedge clk) rst_n = 1'b1;

    for (int bi = 0; bi < 2; bi++)
      for (int ii = 0; ii < 4; ii++)
        for (int c = 0; c < 8; c++)
          for (int m = 0; m < 8; m++)
            for (int s = 0; s < 4; s++)
              run_one(3'(c), 3'(m), 2'(s), bases[bi], 64'h0000_4000_0000_2000,
                      64'h0000_0001_FFFF_FFF8 + 64'(ii), imms[ii]);

    // R1: back-pressure holds result and blocks new input
    @(negedge clk);
    out_ready = 1'b0;
    cls = 3'd0; mode = 3'd1; size = 2'd3; base = 64'h1000; imm = 19'd2; in_valid = 1'b1;
    @(negedge clk);
    mode = 3'd0; base = 64'h5555; cls = 3'd7;
    @(negedge clk);
    chk("R1", "in_ready stalled", 64'(in_ready), 64'd0);
    chk("R1", "held addr", out_addr, 64'h1010);
    chk("R1", "held illegal", 64'(out_illegal), 64'd0);
    @(negedge clk);
    chk("R1", "still held addr", out_addr, 64'h1010);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R1", "next illegal", 64'(out_illegal), 64'd1);
    @(negedge clk);
    chk("R1", "drained", 64'(out_valid), 64'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule